// File: doc/BRIEF.md
# Parallel Shared-Memory Access Resolver

The block accepts one access per cycle from each of `NPORT` processor ports and applies a chosen parallel-machine access rule to them before they reach a small shared storage array. Each port presents a valid bit, a write flag, an address and write data. A mode input selects one of these rules: fully exclusive access; concurrent reads with exclusive writes; or concurrent reads and writes. A fourth code, exclusive reads with concurrent writes, is not supported and is rejected. When concurrent writes are allowed, a policy input sets how colliding writes to one address combine into one stored value. The choices are a pseudo-random winner, the lowest-numbered port, the unsigned maximum, or the wrapped sum.

Every request is taken in the cycle it is presented. There is no ready signal and no back-pressure. Each port's result comes one cycle later. The port either gets read data with its read-valid bit, or has its error bit raised. All reads in a cycle see the contents from before that cycle's writes, so the order of accesses inside a cycle never matters. A flagged access has no effect: a flagged write does not reach storage and a flagged read returns no valid data.

Top module: `pram_resolver`

## Requirements
- R1: After reset, every storage word reads as 0 and all `rd_valid_o` and `err_o` bits are 0.
- R2: A granted read on a port raises that port's `rd_valid_o` one cycle after the request. Its `rd_data_o` equals the word as stored before any write of the same cycle.
- R3: In mode 0 (exclusive access), each valid port whose address matches another valid port's address gets `err_o` set on the next cycle, whether it reads or writes. None of those accesses takes effect.
- R4: In mode 1 (concurrent read, exclusive write), any number of ports may read one address in the same cycle. All of them get `rd_valid_o` and the same data, with no error.
- R5: In mode 1, when two or more ports write the same address in one cycle, every one of those writers is flagged and none of their writes is stored. Reads of that address and writes to other addresses still proceed.
- R6: Mode 2 (exclusive read, concurrent write) is unsupported. Every valid port gets `err_o` on the next cycle and nothing is read or stored.
- R7: In mode 3 (concurrent read and write) with policy 1, the write from the lowest-numbered port among those writing an address is stored.
- R8: In mode 3 with policy 2, the largest write value, compared as unsigned, is stored.
- R9: In mode 3 with policy 3, the sum of all write values to the address, modulo 2^DW, is stored.
- R10: In mode 3 with policy 0, the stored value is one of the values written. The choice comes from a free-running 16-bit LFSR seeded at reset, and that LFSR never holds zero.
- R11: Mode 3 never raises `err_o`, and writes to distinct addresses in one cycle are all stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Access rule: 0 exclusive, 1 concurrent read, 2 unsupported, 3 concurrent read/write |
| policy_i | input | 2 | Write combining in mode 3: 0 random, 1 lowest port, 2 max, 3 sum |
| req_valid_i | input | NPORT | Per-port request valid |
| req_write_i | input | NPORT | Per-port write (1) or read (0) |
| req_addr_i | input | NPORT*AW | Per-port address, port p at bits p*AW +: AW |
| req_wdata_i | input | NPORT*DW | Per-port write data, port p at bits p*DW +: DW |
| rd_valid_o | output | NPORT | Read granted, data valid this cycle |
| rd_data_o | output | NPORT*DW | Per-port read data |
| err_o | output | NPORT | Per-port access-rule violation for the previous cycle's request |

## Verification
The assertions assume that `mode_i` and `policy_i` are stable, known values in each cycle that has requests. They also assume that `req_write_i`, `req_addr_i` and `req_wdata_i` are don't-care only while the matching valid bit is low. The bench changes inputs only on the falling clock edge. It drives every field of every port, zeroing idle ports, so no unknown value reaches the address compare. It reads results back through a port in mode 3, where no conflict can hide the value being checked.

// File: rtl/pram_pkg.sv
package pram_pkg;
  typedef enum logic [1:0] {
    MODE_EXCL  = 2'd0,
    MODE_CRD   = 2'd1,
    MODE_BADWR = 2'd2,
    MODE_CONC  = 2'd3
  } access_mode_e;

  typedef enum logic [1:0] {
    POL_RANDOM = 2'd0,
    POL_PRIO   = 2'd1,
    POL_MAX    = 2'd2,
    POL_SUM    = 2'd3
  } merge_pol_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/pram_lfsr.sv
module pram_lfsr #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] pick_o
);
  import pram_pkg::*;
  logic [15:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LFSR_SEED;
    else state <= {1'b0, state[15:1]} ^ (state[0] ? LFSR_TAPS : 16'h0000);
  end

  assign pick_o = state[PW-1:0];

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != 16'h0000); // R10
endmodule

// File: rtl/pram_conflict.sv
module pram_conflict #(
  parameter int NPORT = 4,
  parameter int AW    = 4
) (
  input  pram_pkg::access_mode_e mode_i,
  input  logic [NPORT-1:0]       vld_i,
  input  logic [NPORT-1:0]       wr_i,
  input  logic [AW-1:0]          addr_i [NPORT],
  output logic [NPORT-1:0]       clash_o
);
  import pram_pkg::*;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      logic any_hit, wr_hit;
      any_hit = 1'b0;
      wr_hit  = 1'b0;
      for (int j = 0; j < NPORT; j++) begin
        if (j != i && vld_i[j] && addr_i[j] == addr_i[i]) begin
          any_hit = 1'b1;
          if (wr_i[j]) wr_hit = 1'b1;
        end
      end
      unique case (mode_i)
        MODE_EXCL:  clash_o[i] = vld_i[i] & any_hit;
        MODE_CRD:   clash_o[i] = vld_i[i] & wr_i[i] & wr_hit;
        MODE_BADWR: clash_o[i] = vld_i[i];
        default:    clash_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pram_merge.sv
module pram_merge #(
  parameter int NPORT = 4,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int SELF  = 0,
  localparam int PW   = $clog2(NPORT)
) (
  input  pram_pkg::merge_pol_e policy_i,
  input  logic [PW-1:0]        start_i,
  input  logic [NPORT-1:0]     wr_ok_i,
  input  logic [AW-1:0]        addr_i  [NPORT],
  input  logic [DW-1:0]        wdata_i [NPORT],
  output logic                 leader_o,
  output logic [DW-1:0]        value_o
);
  import pram_pkg::*;
  logic [NPORT-1:0] hit;
  logic [DW-1:0]    v_prio, v_max, v_sum, v_rnd;

  always_comb begin
    for (int j = 0; j < NPORT; j++)
      hit[j] = wr_ok_i[j] && (addr_i[j] == addr_i[SELF]);
    leader_o = wr_ok_i[SELF];
    for (int j = 0; j < SELF; j++)
      if (hit[j]) leader_o = 1'b0;
  end

  always_comb begin
    logic found_p, found_r;
    int   idx;
    found_p = 1'b0;
    found_r = 1'b0;
    v_prio  = '0;
    v_max   = '0;
    v_sum   = '0;
    v_rnd   = '0;
    for (int j = 0; j < NPORT; j++) begin
      if (hit[j]) begin
        v_sum = v_sum + wdata_i[j];
        if (wdata_i[j] > v_max) v_max = wdata_i[j];
        if (!found_p) begin
          found_p = 1'b1;
          v_prio  = wdata_i[j];
        end
      end
    end
    for (int k = 0; k < NPORT; k++) begin
      idx = (int'(start_i) + k) % NPORT;
      if (!found_r && hit[idx]) begin
        found_r = 1'b1;
        v_rnd   = wdata_i[idx];
      end
    end
    unique case (policy_i)
      POL_RANDOM: value_o = v_rnd;
      POL_PRIO:   value_o = v_prio;
      POL_MAX:    value_o = v_max;
      default:    value_o = v_sum;
    endcase
  end
endmodule

// File: rtl/pram_resolver.sv
module pram_resolver #(
  parameter int NPORT = 4,
  parameter int AW    = 4,
  parameter int DW    = 8,
  localparam int PW    = $clog2(NPORT),
  localparam int DEPTH = 2 ** AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic [1:0]          policy_i,
  input  logic [NPORT-1:0]    req_valid_i,
  input  logic [NPORT-1:0]    req_write_i,
  input  logic [NPORT*AW-1:0] req_addr_i,
  input  logic [NPORT*DW-1:0] req_wdata_i,
  output logic [NPORT-1:0]    rd_valid_o,
  output logic [NPORT*DW-1:0] rd_data_o,
  output logic [NPORT-1:0]    err_o
);
  import pram_pkg::*;

  access_mode_e     mode;
  merge_pol_e       pol;
  logic [AW-1:0]    addr_a  [NPORT];
  logic [DW-1:0]    wdata_a [NPORT];
  logic [DW-1:0]    value_a [NPORT];
  logic [NPORT-1:0] clash, wr_ok, leader, commit, rd_ok;
  logic [PW-1:0]    start;
  logic [DW-1:0]    store [DEPTH];

  assign mode = access_mode_e'(mode_i);
  assign pol  = merge_pol_e'(policy_i);

  pram_lfsr #(.PW(PW)) u_lfsr (.clk(clk), .rst_n(rst_n), .pick_o(start));

  pram_conflict #(.NPORT(NPORT), .AW(AW)) u_conflict (
    .mode_i(mode), .vld_i(req_valid_i), .wr_i(req_write_i),
    .addr_i(addr_a), .clash_o(clash));

  assign wr_ok = req_valid_i & req_write_i & ~clash;
  assign rd_ok = req_valid_i & ~req_write_i & ~clash;
  assign commit = leader;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign addr_a[p]  = req_addr_i[p*AW +: AW];
    assign wdata_a[p] = req_wdata_i[p*DW +: DW];

    pram_merge #(.NPORT(NPORT), .AW(AW), .DW(DW), .SELF(p)) u_merge (
      .policy_i(pol), .start_i(start), .wr_ok_i(wr_ok),
      .addr_i(addr_a), .wdata_i(wdata_a),
      .leader_o(leader[p]), .value_o(value_a[p]));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_data_o[p*DW +: DW] <= '0;
      end else if (rd_ok[p]) begin
        rd_data_o[p*DW +: DW] <= store[addr_a[p]];
      end
    end

    AST_CRD_READ_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd1 && req_valid_i[p] && !req_write_i[p])
      |=> (rd_valid_o[p] && !err_o[p])); // R4

    AST_READ_OR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid_o[p] && err_o[p])); // R2

    for (genvar q = p + 1; q < NPORT; q++) begin : g_pair
      AST_ONE_WRITER_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit[p] && commit[q]) |-> (addr_a[p] != addr_a[q])); // R11
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) store[a] <= '0;
      rd_valid_o <= '0;
      err_o      <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++)
        if (commit[p]) store[addr_a[p]] <= value_a[p];
      rd_valid_o <= rd_ok;
      err_o      <= clash;
    end
  end

  AST_CONC_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3) |=> (err_o == '0)); // R11

  AST_BADMODE_ALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2) |=> (err_o == $past(req_valid_i) && rd_valid_o == '0)); // R6

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i == '0) |=> (err_o == '0 && rd_valid_o == '0)); // R3
endmodule

// File: tb/test_pram_resolver.sv
module test_pram_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]       mode = 2'd3;
  logic [1:0]       policy = 2'd1;
  logic [NP-1:0]    req_valid = '0;
  logic [NP-1:0]    req_write = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP*DW-1:0] req_wdata = '0;
  logic [NP-1:0]    rd_valid;
  logic [NP*DW-1:0] rd_data;
  logic [NP-1:0]    err;

  int  tests = 0;
  int  fails = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pram_resolver #(.NPORT(NP), .AW(AW), .DW(DW)) i_pram_resolver (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .policy_i(policy),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .err_o(err));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic put(input int p, input bit w, input int a, input int d);
    req_valid[p] = 1'b1;
    req_write[p] = w;
    req_addr[p*AW +: AW] = AW'(a);
    req_wdata[p*DW +: DW] = DW'(d);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic mem_read(input int a, output int v);
    logic [1:0] m;
    m = mode;
    mode = 2'd3;
    idle();
    put(0, 1'b0, a, 0);
    step();
    v = int'(rd_data[DW-1:0]);
    idle();
    mode = m;
    step();
  endtask

  task automatic mem_write(input int a, input int d);
    mode = 2'd3; policy = 2'd1;
    idle(); put(0, 1'b1, a, d); step(); idle();
  endtask

  task automatic t_reset();
    int v;
    chk("R1 err after reset", int'(err), 0);
    chk("R1 rd_valid after reset", int'(rd_valid), 0);
    mem_read(5, v);
    chk("R1 word 5 cleared", v, 0);
    mem_read(15, v);
    chk("R1 word 15 cleared", v, 0);
  endtask

  task automatic t_read_old();
    int v;
    mem_write(3, 8'h11);
    mode = 2'd3; policy = 2'd1;
    idle(); put(0, 1'b0, 3, 0); put(1, 1'b1, 3, 8'h22);
    step();
    chk("R2 rd_valid port0", int'(rd_valid[0]), 1);
    chk("R2 read sees old word", int'(rd_data[DW-1:0]), 8'h11);
    idle(); step();
    mem_read(3, v);
    chk("R2 write landed after", v, 8'h22);
  endtask

  task automatic t_excl();
    int v;
    mem_write(2, 8'h40);
    mode = 2'd0;
    idle(); put(0, 1'b0, 2, 0); put(1, 1'b1, 2, 8'h55); put(2, 1'b0, 7, 0);
    step();
    chk("R3 err colliding ports", int'(err), 4'b0011);
    chk("R3 only lone read valid", int'(rd_valid), 4'b0100);
    idle(); step();
    mem_read(2, v);
    chk("R3 colliding write dropped", v, 8'h40);
  endtask

  task automatic t_crd_reads();
    mode = 2'd1;
    idle();
    for (int p = 0; p < NP; p++) put(p, 1'b0, 2, 0);
    step();
    chk("R4 all reads granted", int'(rd_valid), 4'b1111);
    chk("R4 no error", int'(err), 0);
    for (int p = 0; p < NP; p++)
      chk("R4 same data", int'(rd_data[p*DW +: DW]), 8'h40);
    idle(); step();
  endtask

  task automatic t_crd_writes();
    int v;
    mode = 2'd1;
    idle();
    put(0, 1'b1, 4, 8'h01); put(2, 1'b1, 4, 8'h02);
    put(1, 1'b0, 4, 0);     put(3, 1'b1, 5, 8'h33);
    step();
    chk("R5 both writers flagged", int'(err), 4'b0101);
    chk("R5 reader granted", int'(rd_valid), 4'b0010);
    chk("R5 reader data", int'(rd_data[1*DW +: DW]), 0);
    idle(); step();
    mem_read(4, v);
    chk("R5 collided word untouched", v, 0);
    mem_read(5, v);
    chk("R5 lone write stored", v, 8'h33);
  endtask

  task automatic t_badmode();
    int v;
    mode = 2'd2;
    idle(); put(0, 1'b1, 6, 8'h77); put(1, 1'b0, 6, 0);
    step();
    chk("R6 all valid flagged", int'(err), 4'b0011);
    chk("R6 no read granted", int'(rd_valid), 0);
    idle(); step();
    chk("R6 idle clears flags", int'(err), 0);
    mem_read(6, v);
    chk("R6 nothing stored", v, 0);
  endtask

  task automatic t_prio();
    int v;
    mode = 2'd3; policy = 2'd1;
    idle();
    put(1, 1'b1, 8, 8'h10); put(2, 1'b1, 8, 8'h05); put(3, 1'b1, 8, 8'h30);
    put(0, 1'b1, 9, 8'h99);
    step();
    chk("R11 no error in mode 3", int'(err), 0);
    idle(); step();
    mem_read(8, v);
    chk("R7 lowest port wins", v, 8'h10);
    mem_read(9, v);
    chk("R11 distinct address stored", v, 8'h99);
  endtask

  task automatic t_max();
    int v;
    mode = 2'd3; policy = 2'd2;
    idle();
    put(0, 1'b1, 11, 8'h7F); put(1, 1'b1, 11, 8'hF0); put(3, 1'b1, 11, 8'h80);
    step(); idle(); step();
    mem_read(11, v);
    chk("R8 unsigned max", v, 8'hF0);
  endtask

  task automatic t_sum();
    int v;
    mode = 2'd3; policy = 2'd3;
    idle();
    put(0, 1'b1, 12, 8'hF0); put(2, 1'b1, 12, 8'h20); put(3, 1'b1, 12, 8'h15);
    step(); idle(); step();
    mem_read(12, v);
    chk("R9 wrapped sum", v, 8'h25);
  endtask

  task automatic t_random();
    int v;
    for (int r = 0; r < 8; r++) begin
      mode = 2'd3; policy = 2'd0;
      idle();
      put(0, 1'b1, 10, 8'hA1); put(1, 1'b1, 10, 8'hB2);
      put(2, 1'b1, 10, 8'hC3); put(3, 1'b1, 10, 8'hD4);
      step();
      chk("R10 no error", int'(err), 0);
      idle();
      repeat (r) step();
      mem_read(10, v);
      chk("R10 value is a written one",
          int'(v == 8'hA1 || v == 8'hB2 || v == 8'hC3 || v == 8'hD4), 1);
    end
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_read_old();
    t_excl();
    t_crd_reads();
    t_crd_writes();
    t_badmode();
    t_prio();
    t_max();
    t_sum();
    t_random();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule